// File: doc/BRIEF.md
# Dual-Mode Segment Address Translator

This block turns a 16-bit segment selector and a 32-bit effective offset into a 32-bit linear address. A single mode input chooses how the segment part is formed. In real mode, the selector is moved up by four bit positions and added to the offset. In protected mode, the selector picks one entry of a small base-address table, and that entry is added to the offset. There are two such tables, a global one and a local one. Bit 2 of the selector chooses between them, and bits [15:3] give the entry number.

Software or a controller fills the two tables through a simple write port. The port takes an enable, a table choice, an entry number and a 32-bit base. Each accepted request produces one registered result one clock later. The result carries a valid strobe, the address, and two flags. The first flag says that paging is on, so a later stage must still translate the address. The second flag says that a protected-mode entry number fell outside the table.

Top module: `seg_xlat_top`

## Requirements
- R1: With `prot_mode`=0, the address presented one cycle after a request equals `(sel << 4) + offset` taken modulo 2^32, with no masking of the upper selector bits.
- R2: With `prot_mode`=1 and an entry number inside the table, the address equals the stored base plus `offset`, modulo 2^32.
- R3: In protected mode, selector bit 2 picks the table (1 = local, 0 = global), bits [15:3] are the entry number, and bits [1:0] have no effect on the result.
- R4: A protected-mode request whose entry number (selector bits [15:3]) is at least `DEPTH` uses a base of zero and raises `range_err` in its result cycle only. `range_err` is never raised for a real-mode request.
- R5: `out_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise. `phys_addr` keeps its last value while no result is produced.
- R6: `xlat_needed` equals the `paging_en` value of the request that it accompanies. `phys_addr` is the untranslated linear address whether paging is on or off.
- R7: While `rst` is high, at the next clock edge `out_valid`, `xlat_needed` and `range_err` go to 0 and `phys_addr` goes to 0.
- R8: A write with `wr_en`=1 stores `wr_base` into entry `wr_idx` of the table chosen by `wr_local` (1 = local). The new value is seen by requests from the following cycle on, and no other entry of either table changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| prot_mode | input | 1 | 1 = table-based translation, 0 = shift-and-add |
| sel | input | 16 | Segment selector |
| offset | input | 32 | Effective offset |
| paging_en | input | 1 | Paging state that travels with the request |
| wr_en | input | 1 | Table write enable |
| wr_local | input | 1 | Table to write: 1 = local, 0 = global |
| wr_idx | input | IDX_W (3) | Entry number to write |
| wr_base | input | 32 | Base value to write |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| phys_addr | output | 32 | Linear address, passed to the physical side untranslated |
| xlat_needed | output | 1 | Paging was on; the address needs further translation |
| range_err | output | 1 | Protected-mode entry number was out of range |

## Verification
Real-mode vectors include small values and an all-ones selector with a near-full offset. Together they show whether the shift amount is right and whether the carry out of bit 31 is dropped, not the upper selector bits. Protected-mode vectors use the same entry number in both tables, and once with both low selector bits set. This separates a correct table choice from one that reads the wrong table or indexes with the wrong bit field. A base near 2^32 checks the wrap. Entry numbers just past the table and at the maximum show the zero base and the error flag. Idle cycles, a rewrite of one global entry followed by reads of both tables, and a paging-on request check the strobe, the hold, write isolation and the flag.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  localparam int SEL_W       = 16;
  localparam int ADDR_W      = 32;
  localparam int SEL_IDX_W   = 13;
  localparam int SEL_IDX_LSB = 3;
  localparam int SEL_TBL_BIT = 2;
  localparam int REAL_SHIFT  = 4;

  typedef enum logic {
    TBL_GLOBAL = 1'b0,
    TBL_LOCAL  = 1'b1
  } tbl_sel_e;

  typedef struct packed {
    logic [SEL_IDX_W-1:0] idx;
    logic                 tbl;
    logic [1:0]           rpl;
  } selector_t;

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] addr;
    logic              xlat;
    logic              err;
  } xlat_result_t;

  function automatic selector_t split_sel(input logic [SEL_W-1:0] s);
    selector_t r;
    r.idx = s[SEL_W-1:SEL_IDX_LSB];
    r.tbl = s[SEL_TBL_BIT];
    r.rpl = s[1:0];
    return r;
  endfunction

endpackage

// File: rtl/seg_base_table.sv
module seg_base_table #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              waddr_ok;
  logic              raddr_ok;

  assign waddr_ok = ({1'b0, waddr} < DEPTH_L);
  assign raddr_ok = ({1'b0, raddr} < DEPTH_L);

  always_ff @(posedge clk) begin
    if (we && waddr_ok) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = raddr_ok ? mem[raddr] : '0;

endmodule

// File: rtl/seg_base_lookup.sv
module seg_base_lookup
  import seg_xlat_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [SEL_IDX_W-1:0] sel_idx,
  input  logic                 sel_tbl,
  input  logic [ADDR_W-1:0]    glb_rdata,
  input  logic [ADDR_W-1:0]    loc_rdata,
  output logic [AW-1:0]        rd_addr,
  output logic [ADDR_W-1:0]    base,
  output logic                 out_of_range
);

  localparam logic [SEL_IDX_W:0] DEPTH_L = (SEL_IDX_W+1)'(DEPTH);

  tbl_sel_e          which;
  logic [ADDR_W-1:0] picked;

  assign rd_addr      = sel_idx[AW-1:0];
  assign out_of_range = ({1'b0, sel_idx} >= DEPTH_L);
  assign which        = tbl_sel_e'(sel_tbl);

  always_comb begin
    unique case (which)
      TBL_LOCAL:  picked = loc_rdata;
      default:    picked = glb_rdata;
    endcase
  end

  assign base = out_of_range ? '0 : picked;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_xlat_pkg::*;
(
  input  logic              prot_mode,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] prot_base,
  output logic [ADDR_W-1:0] linear
);

  logic [ADDR_W-1:0] real_base;
  logic [ADDR_W-1:0] seg_part;

  assign real_base = ADDR_W'(sel) << REAL_SHIFT;
  assign seg_part  = prot_mode ? prot_base : real_base;
  assign linear    = seg_part + offset;

endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
  import seg_xlat_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             prot_mode,
  input  logic [15:0]      sel,
  input  logic [31:0]      offset,
  input  logic             paging_en,
  input  logic             wr_en,
  input  logic             wr_local,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_base,
  output logic             out_valid,
  output logic [31:0]      phys_addr,
  output logic             xlat_needed,
  output logic             range_err
);

  localparam int NUM_TBL = 2;

  selector_t         sel_f;
  logic [IDX_W-1:0]  rd_addr;
  logic [ADDR_W-1:0] tbl_rdata [NUM_TBL];
  logic [ADDR_W-1:0] prot_base;
  logic              oor;
  logic [ADDR_W-1:0] linear;
  xlat_result_t      res_q;

  assign sel_f = split_sel(sel);

  for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
    logic tbl_we;
    assign tbl_we = wr_en && (wr_local == g[0]);
    seg_base_table #(
      .DEPTH  (DEPTH),
      .DATA_W (ADDR_W)
    ) tbl_i (
      .clk   (clk),
      .we    (tbl_we),
      .waddr (wr_idx),
      .wdata (wr_base),
      .raddr (rd_addr),
      .rdata (tbl_rdata[g])
    );
  end

  seg_base_lookup #(
    .DEPTH (DEPTH)
  ) lookup_i (
    .sel_idx      (sel_f.idx),
    .sel_tbl      (sel_f.tbl),
    .glb_rdata    (tbl_rdata[TBL_GLOBAL]),
    .loc_rdata    (tbl_rdata[TBL_LOCAL]),
    .rd_addr      (rd_addr),
    .base         (prot_base),
    .out_of_range (oor)
  );

  seg_addr_gen gen_i (
    .prot_mode (prot_mode),
    .sel       (sel),
    .offset    (offset),
    .prot_base (prot_base),
    .linear    (linear)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else begin
      res_q.valid <= req_valid;
      res_q.xlat  <= req_valid && paging_en;
      res_q.err   <= req_valid && prot_mode && oor;
      if (req_valid) begin
        res_q.addr <= linear;
      end
    end
  end

  assign out_valid   = res_q.valid;
  assign phys_addr   = res_q.addr;
  assign xlat_needed = res_q.xlat;
  assign range_err   = res_q.err;

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             prot_mode,
  input logic [15:0]      sel,
  input logic [31:0]      offset,
  input logic             paging_en,
  input logic             out_valid,
  input logic [31:0]      phys_addr,
  input logic             xlat_needed,
  input logic             range_err
);

  localparam logic [13:0] DEPTH_L = 14'(DEPTH);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid); // R5
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid); // R5
  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(phys_addr)); // R5
  AST_REAL_SUM: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !prot_mode) |=>
      (phys_addr == $past({12'b0, sel, 4'b0} + offset))); // R1
  AST_REAL_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !prot_mode) |=> !range_err); // R4
  AST_OOR_ZERO_BASE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && prot_mode && ({1'b0, sel[15:3]} >= DEPTH_L)) |=>
      (range_err && phys_addr == $past(offset))); // R4
  AST_IN_RANGE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && prot_mode && ({1'b0, sel[15:3]} < DEPTH_L)) |=> !range_err); // R4
  AST_PAGING_FLAG: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (xlat_needed == $past(paging_en))); // R6
  AST_FLAGS_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    (range_err || xlat_needed) |-> out_valid); // R5

endmodule

bind seg_xlat_top seg_xlat_chk #(.DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .prot_mode   (prot_mode),
  .sel         (sel),
  .offset      (offset),
  .paging_en   (paging_en),
  .out_valid   (out_valid),
  .phys_addr   (phys_addr),
  .xlat_needed (xlat_needed),
  .range_err   (range_err)
);

// File: tb/seg_xlat_top_tb_top.sv
`timescale 1ns/1ps
module seg_xlat_top_tb_top;

  localparam int DEPTH = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic             req_valid;
  logic             prot_mode;
  logic [15:0]      sel;
  logic [31:0]      offset;
  logic             paging_en;
  logic             wr_en;
  logic             wr_local;
  logic [IDX_W-1:0] wr_idx;
  logic [31:0]      wr_base;
  logic             out_valid;
  logic [31:0]      phys_addr;
  logic             xlat_needed;
  logic             range_err;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  seg_xlat_top #(.DEPTH(DEPTH)) dut_i (
    .clk, .rst, .req_valid, .prot_mode, .sel, .offset, .paging_en,
    .wr_en, .wr_local, .wr_idx, .wr_base,
    .out_valid, .phys_addr, .xlat_needed, .range_err
  );

  typedef struct packed {
    logic        prot;
    logic [15:0] s;
    logic [31:0] off;
    logic        pg;
    logic [31:0] exp_addr;
    logic        exp_err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h1234, 32'h0000_0010, 1'b0, 32'h0001_2350, 1'b0}, // R1 basic
    '{1'b0, 16'hFFFF, 32'hFFFF_FFF0, 1'b0, 32'h000F_FFE0, 1'b0}, // R1 wrap
    '{1'b0, 16'h0008, 32'h0000_0100, 1'b0, 32'h0000_0180, 1'b0}, // R1 no table
    '{1'b1, 16'h0000, 32'h0000_0010, 1'b0, 32'h0001_0010, 1'b0}, // R3 global 0
    '{1'b1, 16'h0004, 32'h0000_0010, 1'b0, 32'h0002_0010, 1'b0}, // R3 local 0
    '{1'b1, 16'h001B, 32'h0000_0005, 1'b0, 32'h8000_0005, 1'b0}, // R3 global 3, low bits set
    '{1'b1, 16'h001C, 32'h0000_0005, 1'b0, 32'h4000_0005, 1'b0}, // R3 local 3
    '{1'b1, 16'h0038, 32'h0000_0020, 1'b0, 32'h0000_0010, 1'b0}, // R2 wrap
    '{1'b1, 16'h003C, 32'h0000_0000, 1'b0, 32'h0000_1000, 1'b0}, // R2 local 7
    '{1'b1, 16'h0040, 32'h0000_1234, 1'b0, 32'h0000_1234, 1'b1}, // R4 just past
    '{1'b1, 16'hFFFC, 32'h0000_0077, 1'b0, 32'h0000_0077, 1'b1}, // R4 max index
    '{1'b0, 16'h0001, 32'h0000_0001, 1'b1, 32'h0000_0011, 1'b0}  // R6 paging on
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_tab(input logic loc, input logic [IDX_W-1:0] idx, input logic [31:0] base);
    @(negedge clk);
    wr_en = 1'b1; wr_local = loc; wr_idx = idx; wr_base = base;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic req(input logic p, input logic [15:0] s, input logic [31:0] off, input logic pg);
    req_valid = 1'b1; prot_mode = p; sel = s; offset = off; paging_en = pg;
  endtask

  function automatic string addr_tag(input vec_t v);
    if (!v.prot) return "R1";
    if (v.exp_err) return "R4";
    if (v.s[15:3] == 13'd7) return "R2";
    return "R3";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; prot_mode = 1'b0; sel = '0; offset = '0;
    paging_en = 1'b0; wr_en = 1'b0; wr_local = 1'b0; wr_idx = '0; wr_base = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 valid", 32'(out_valid), 32'd0);
    check("R7 addr", phys_addr, 32'd0);
    check("R7 flags", {30'd0, xlat_needed, range_err}, 32'd0);
    rst = 1'b0;

    // R8 table fill
    wr_tab(1'b0, 3'd0, 32'h0001_0000);
    wr_tab(1'b0, 3'd3, 32'h8000_0000);
    wr_tab(1'b0, 3'd7, 32'hFFFF_FFF0);
    wr_tab(1'b1, 3'd0, 32'h0002_0000);
    wr_tab(1'b1, 3'd3, 32'h4000_0000);
    wr_tab(1'b1, 3'd7, 32'h0000_1000);

    // vector table, back-to-back requests
    for (int i = 0; i < NV; i++) begin
      req(VECS[i].prot, VECS[i].s, VECS[i].off, VECS[i].pg);
      @(negedge clk);
      check(addr_tag(VECS[i]), phys_addr, VECS[i].exp_addr);
      check("R5 valid", 32'(out_valid), 32'd1);
      check("R4 err", 32'(range_err), 32'(VECS[i].exp_err));
      check("R6 xlat", 32'(xlat_needed), 32'(VECS[i].pg));
    end

    // R5 idle: no strobe, address holds
    req_valid = 1'b0; offset = 32'hDEAD_0000;
    @(negedge clk);
    check("R5 idle valid", 32'(out_valid), 32'd0);
    check("R5 hold addr", phys_addr, 32'h0000_0011);
    check("R6 flag cleared", 32'(xlat_needed), 32'd0);

    // R8 rewrite global 3, local 3 untouched
    wr_tab(1'b0, 3'd3, 32'h1111_0000);
    req(1'b1, 16'h001C, 32'h0, 1'b0);
    @(negedge clk);
    check("R8 local kept", phys_addr, 32'h4000_0000);
    req(1'b1, 16'h0018, 32'h0, 1'b0);
    @(negedge clk);
    check("R8 global new", phys_addr, 32'h1111_0000);
    req(1'b1, 16'h0000, 32'h0, 1'b0);
    @(negedge clk);
    check("R8 global 0 kept", phys_addr, 32'h0001_0000);

    // R7 reset during traffic
    req(1'b1, 16'hFFFC, 32'h5, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid valid", 32'(out_valid), 32'd0);
    check("R7 mid addr", phys_addr, 32'd0);
    check("R7 mid flags", {30'd0, xlat_needed, range_err}, 32'd0);
    rst = 1'b0; req_valid = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule